// File: doc/BRIEF.md
# SPI Master Character Transceiver with Transmit Holding Register

The block is the master side of an SPI link that moves one 8-bit character at a time. Software puts a character into a one-entry transmit holding register. When the shifter is idle, that character moves into the shifter and the holding register is free for the next write. While a character shifts out on MOSI, MSB first, the same serial clock captures MISO into a separate receive shifter. The completed word then lands in a receive holding register and a data-ready flag rises.

Chip-select is generated inside the block. It falls one bit period before the first data bit and rises one bit period after the last one. One further bit period of idle follows before another character may begin. A hold command keeps chip-select low across characters until a release command arrives. For slaves that must not be overrun, an optional receive handshake keeps a pending character waiting until the previous received character has been read. The bit period is a count of system clocks taken from an input when each character starts.

Top module: `spim_hold_xcvr`

## Requirements
- R1: A write strobe is accepted only while `tx_ready` is high. A write made while `tx_ready` is low is discarded: the held character is unchanged and the discarded value is never transmitted.
- R2: `tx_ready` is high exactly when the transmitter is enabled and the holding register is empty. `tx_empty` is high when, in addition, no character is being shifted. Both are low while the transmitter is disabled. After reset the transmitter is disabled, `spi_cs_n` is high, `spi_sck` and `spi_mosi` are low, and `rd_data`, `rx_ready` and `overrun` are zero.
- R3: A character starts on the first clock edge at which the shifter is idle, the transmitter is enabled, the holding register is full and the handshake allows it. At that edge the holding register empties and chip-select falls. With an idle shifter, this edge is the second edge after the write strobe.
- R4: While `rx_gate` is 1 and `rx_ready` is 1, a pending character does not start. It starts on the edge after the one at which a read clears `rx_ready`. While `rx_gate` is 0, a character starts regardless of `rx_ready`.
- R5: A frame with bit period P lasts 11·P clocks from the start edge, in this order: P clocks with chip-select low and no clock, then eight bits of P clocks each, then P clocks of hold with chip-select low, then P clocks with chip-select high. Each bit shows `spi_mosi` (bit 7 first) for its whole period. `spi_sck` is low for the first floor(P/2) clocks of each bit and high for the rest. `spi_sck` and `spi_mosi` are low outside the eight bits.
- R6: `spi_miso` is sampled at each rising edge of the serial clock and assembled MSB first. On the edge that samples the eighth bit, 8·P + floor(P/2) + 1 edges after the start edge, the word is written to `rd_data` and `rx_ready` rises.
- R7: A read strobe clears `rx_ready` unless a character completes at the same edge, in which case `rx_ready` stays 1.
- R8: A character that completes while `rx_ready` is 1, with no read at that edge, sets `overrun` and overwrites `rd_data`.
- R9: `overrun` is cleared only by the clear-status command. A clear that meets a new overrun at the same edge leaves `overrun` set.
- R10: The hold command keeps `spi_cs_n` low from the next edge onward, through frame gaps and idle time, until a release command arrives. With no hold active, chip-select follows the frame timing of R5. If both commands arrive together, the release wins.
- R11: The bit period is `bit_div` system clocks, latched at each start edge. Values below 2 are treated as 2.
- R12: The enable and disable commands switch the transmitter on and off, and the disable wins if both arrive together. Disabling during a frame lets that frame finish. While the transmitter is disabled, writes are discarded and no held character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_div | input | DIV_W | Bit period in system clocks (values below 2 are treated as 2) |
| rx_gate | input | 1 | Receive handshake: hold a pending character while received data is unread |
| wr_thr | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | CHAR_W | Character to transmit |
| rd_rhr | input | 1 | Read strobe for the receive holding register |
| rd_data | output | CHAR_W | Receive holding register |
| cmd_tx_on | input | 1 | Enable-transmitter command strobe |
| cmd_tx_off | input | 1 | Disable-transmitter command strobe |
| cmd_cs_hold | input | 1 | Force chip-select low |
| cmd_cs_free | input | 1 | Release forced chip-select |
| cmd_clr_sts | input | 1 | Clear the overrun flag |
| tx_ready | output | 1 | Holding register empty and transmitter enabled |
| tx_empty | output | 1 | All written characters fully shifted out and transmitter enabled |
| rx_ready | output | 1 | Unread received character present |
| overrun | output | 1 | A received character overwrote an unread one |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip-select, active low |

## Verification
The bench measures every result in edges from a start edge. A start edge comes two edges after a write strobe when the shifter is idle, or one edge after the read that releases a gated character. Counting from the start edge:
- chip-select falls at once;
- each bit's clock and data follow at fixed offsets of P and floor(P/2);
- `rx_ready` and `rd_data` change 8·P + floor(P/2) + 1 edges later;
- chip-select rises after 10·P edges;
- the shifter is idle again after 11·P edges.

A behavioural model in the bench counts these edges with plain integers. It is updated at each rising edge from the inputs driven half a cycle earlier. Every output is compared with the model at the following falling edge, so each result is checked in the first cycle it is due and in every cycle after. Directed checks add the single-cycle moments: the write at the same edge as a full register, the read that releases a gated character, a disable in mid-frame, and the measured chip-select width with a bit period below 2.

// File: rtl/spim_pkg.sv
package spim_pkg;

   // Frame phase of the serial sequencer
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LEAD  = 3'd1,
      PH_DATA  = 3'd2,
      PH_TRAIL = 3'd3,
      PH_GAP   = 3'd4
   } spim_phase_e;

   // One-cycle command strobes from the register interface
   typedef struct packed {
      logic tx_on;
      logic tx_off;
      logic cs_hold;
      logic cs_free;
      logic clr_sts;
   } spim_cmd_s;

endpackage

// File: rtl/spim_frame_timer.sv
module spim_frame_timer
   import spim_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int CHAR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] bit_div,
   output spim_phase_e      phase,
   output logic             busy,
   output logic             cs_frame,
   output logic             sck_level,
   output logic             sample_pt,
   output logic             bit_end,
   output logic             last_bit
);

   localparam int BIT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
   localparam logic [DIV_W-1:0] PER_MIN = DIV_W'(2);
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(CHAR_W - 1);

   generate
      if (DIV_W < 2) begin : g_bad_div_w
         $error("spim_frame_timer: DIV_W must be at least 2");
      end
   endgenerate

   spim_phase_e      phase_q;
   logic [DIV_W-1:0] per_q;
   logic [DIV_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_q;
   logic [DIV_W-1:0] per_eff;
   logic [DIV_W-1:0] half;
   logic             period_end;

   assign per_eff    = (bit_div < PER_MIN) ? PER_MIN : bit_div;
   assign half       = per_q >> 1;
   assign busy       = (phase_q != PH_IDLE);
   assign period_end = busy && (cnt_q == (per_q - DIV_W'(1)));
   assign last_bit   = (bit_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         per_q   <= PER_MIN;
         cnt_q   <= '0;
         bit_q   <= '0;
      end else if (phase_q == PH_IDLE) begin
         if (start) begin
            phase_q <= PH_LEAD;
            per_q   <= per_eff;
            cnt_q   <= '0;
            bit_q   <= '0;
         end
      end else if (period_end) begin
         cnt_q <= '0;
         unique case (phase_q)
            PH_LEAD:  phase_q <= PH_DATA;
            PH_DATA: begin
               if (last_bit) phase_q <= PH_TRAIL;
               else          bit_q   <= bit_q + BIT_W'(1);
            end
            PH_TRAIL: phase_q <= PH_GAP;
            PH_GAP:   phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign phase     = phase_q;
   assign cs_frame  = (phase_q == PH_LEAD) || (phase_q == PH_DATA) || (phase_q == PH_TRAIL);
   assign sck_level = (phase_q == PH_DATA) && (cnt_q >= half);
   assign sample_pt = (phase_q == PH_DATA) && (cnt_q == half);
   assign bit_end   = (phase_q == PH_DATA) && period_end;

   AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (per_q >= PER_MIN)); // R11
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (phase_q == PH_IDLE)); // R3
   AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < per_q)); // R5

endmodule

// File: rtl/spim_char_shifter.sv
module spim_char_shifter #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CHAR_W-1:0] load_word,
   input  logic              bit_end,
   input  logic              sample_pt,
   input  logic              miso,
   output logic              mosi_bit,
   output logic [CHAR_W-1:0] rx_word
);

   generate
      if (CHAR_W < 2) begin : g_bad_char_w
         $error("spim_char_shifter: CHAR_W must be at least 2");
      end
   endgenerate

   logic [CHAR_W-1:0] tx_q;
   logic [CHAR_W-1:0] rx_q;

   // Transmit side: MSB leaves first, shift at the end of each bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= load_word;
      end else if (bit_end) begin
         tx_q <= {tx_q[CHAR_W-2:0], 1'b0};
      end
   end

   // Receive side: one sample per rising serial clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (sample_pt) begin
         rx_q <= {rx_q[CHAR_W-2:0], miso};
      end
   end

   assign mosi_bit = tx_q[CHAR_W-1];
   // Word including the bit being sampled now; valid on the last sample
   assign rx_word  = {rx_q[CHAR_W-2:0], miso};

   AST_LOAD_OUTSIDE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!bit_end && !sample_pt)); // R3

endmodule

// File: rtl/spim_ctrl_regs.sv
module spim_ctrl_regs
   import spim_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_word,
   input  logic              rd_en,
   input  spim_cmd_s         cmd,
   input  logic              rx_gate,
   input  logic              busy,
   input  logic              rx_done,
   input  logic [CHAR_W-1:0] rx_word,
   output logic              start,
   output logic [CHAR_W-1:0] load_word,
   output logic              tx_ready,
   output logic              tx_empty,
   output logic              rx_ready,
   output logic              overrun,
   output logic [CHAR_W-1:0] rhr,
   output logic              cs_hold
);

   logic              en_q;
   logic              thr_full;
   logic [CHAR_W-1:0] thr_q;
   logic [CHAR_W-1:0] rhr_q;
   logic              rxr_q;
   logic              ovr_q;
   logic              hold_q;
   logic              wr_take;

   assign tx_ready = en_q & ~thr_full;
   assign tx_empty = tx_ready & ~busy;
   assign wr_take  = wr_en & tx_ready;
   assign start    = en_q & thr_full & ~busy & (~rx_gate | ~rxr_q);

   // Transmitter enable: disable wins over enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           en_q <= 1'b0;
      else if (cmd.tx_off)  en_q <= 1'b0;
      else if (cmd.tx_on)   en_q <= 1'b1;
   end

   // Forced chip-select: release wins over hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hold_q <= 1'b0;
      else if (cmd.cs_free)  hold_q <= 1'b0;
      else if (cmd.cs_hold)  hold_q <= 1'b1;
   end

   // Transmit holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_full <= 1'b0;
         thr_q    <= '0;
      end else begin
         if (start)        thr_full <= 1'b0;
         else if (wr_take) thr_full <= 1'b1;
         if (wr_take)      thr_q    <= wr_word;
      end
   end

   // Receive holding register and its flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rhr_q <= '0;
         rxr_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (rx_done) begin
            rhr_q <= rx_word;
            rxr_q <= 1'b1;
         end else if (rd_en) begin
            rxr_q <= 1'b0;
         end
         if (rx_done && rxr_q && !rd_en) ovr_q <= 1'b1;
         else if (cmd.clr_sts)           ovr_q <= 1'b0;
      end
   end

   assign load_word = thr_q;
   assign rx_ready  = rxr_q;
   assign overrun   = ovr_q;
   assign rhr       = rhr_q;
   assign cs_hold   = hold_q;

   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_ready) |=> (thr_q == $past(thr_q))); // R1
   AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> ($past(rxr_q) && $past(rx_done))); // R8
   AST_CLEAR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.clr_sts && !rx_done) |=> !ovr_q); // R9
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rx_done) |=> !rxr_q); // R7
   AST_OFF_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.tx_off |=> !start); // R12

endmodule

// File: rtl/spim_hold_xcvr.sv
module spim_hold_xcvr
   import spim_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  bit_div,
   input  logic              rx_gate,
   input  logic              wr_thr,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              rd_rhr,
   output logic [CHAR_W-1:0] rd_data,
   input  logic              cmd_tx_on,
   input  logic              cmd_tx_off,
   input  logic              cmd_cs_hold,
   input  logic              cmd_cs_free,
   input  logic              cmd_clr_sts,
   output logic              tx_ready,
   output logic              tx_empty,
   output logic              rx_ready,
   output logic              overrun,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);

   spim_cmd_s         cmd;
   spim_phase_e       phase;
   logic              start;
   logic              busy;
   logic              cs_frame;
   logic              sck_level;
   logic              sample_pt;
   logic              bit_end;
   logic              last_bit;
   logic              rx_done;
   logic              mosi_bit;
   logic              cs_hold;
   logic [CHAR_W-1:0] load_word;
   logic [CHAR_W-1:0] rx_word;

   assign cmd = '{tx_on:   cmd_tx_on,
                  tx_off:  cmd_tx_off,
                  cs_hold: cmd_cs_hold,
                  cs_free: cmd_cs_free,
                  clr_sts: cmd_clr_sts};

   assign rx_done = sample_pt & last_bit;

   spim_frame_timer #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bit_div   (bit_div),
      .phase     (phase),
      .busy      (busy),
      .cs_frame  (cs_frame),
      .sck_level (sck_level),
      .sample_pt (sample_pt),
      .bit_end   (bit_end),
      .last_bit  (last_bit)
   );

   spim_char_shifter #(.CHAR_W(CHAR_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_word (load_word),
      .bit_end   (bit_end),
      .sample_pt (sample_pt),
      .miso      (spi_miso),
      .mosi_bit  (mosi_bit),
      .rx_word   (rx_word)
   );

   spim_ctrl_regs #(.CHAR_W(CHAR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_thr),
      .wr_word   (wr_data),
      .rd_en     (rd_rhr),
      .cmd       (cmd),
      .rx_gate   (rx_gate),
      .busy      (busy),
      .rx_done   (rx_done),
      .rx_word   (rx_word),
      .start     (start),
      .load_word (load_word),
      .tx_ready  (tx_ready),
      .tx_empty  (tx_empty),
      .rx_ready  (rx_ready),
      .overrun   (overrun),
      .rhr       (rd_data),
      .cs_hold   (cs_hold)
   );

   assign spi_sck  = sck_level;
   assign spi_mosi = (phase == PH_DATA) & mosi_bit;
   assign spi_cs_n = ~(cs_hold | cs_frame);

   AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n); // R5
   AST_GATE_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !($past(rx_gate) && $past(rx_ready))); // R4
   AST_HOLD_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_cs_hold && !cmd_cs_free) |=> !spi_cs_n); // R10
   AST_RX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> ($past(busy) && !$past(spi_cs_n))); // R6

endmodule

// File: tb/sim_spim_hold_xcvr.sv
module sim_spim_hold_xcvr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bit_div = 8'd4;
   logic       rx_gate = 1'b0;
   logic       wr_thr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_rhr = 1'b0;
   logic [7:0] rd_data;
   logic       c_on = 1'b0, c_off = 1'b0, c_hold = 1'b0, c_free = 1'b0, c_clr = 1'b0;
   logic       tx_ready, tx_empty, rx_ready, overrun;
   logic       spi_sck, spi_mosi, spi_miso, spi_cs_n;

   always #10 clk = ~clk;   // 50 MHz

   spim_hold_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .rx_gate(rx_gate),
      .wr_thr(wr_thr), .wr_data(wr_data), .rd_rhr(rd_rhr), .rd_data(rd_data),
      .cmd_tx_on(c_on), .cmd_tx_off(c_off), .cmd_cs_hold(c_hold),
      .cmd_cs_free(c_free), .cmd_clr_sts(c_clr),
      .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ready(rx_ready),
      .overrun(overrun), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done_run = 1'b0;

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_busy = 0;       // clocks left in the current frame
   int         m_per = 2;
   bit         m_en = 0, m_thr_full = 0, m_rxr = 0, m_ovr = 0, m_hold = 0;
   logic [7:0] m_thr = 0, m_rhr = 0, m_cur_tx = 0, m_cur_slave = 0;
   int         m_frames = 0;
   logic [7:0] sent_q[$];

   function automatic logic [7:0] slave_pat(int n);
      return 8'((n * 29) ^ 8'h5C);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_per = 2; m_en = 0; m_thr_full = 0; m_rxr = 0;
         m_ovr = 0; m_hold = 0; m_thr = 0; m_rhr = 0; m_cur_tx = 0;
      end else begin
         automatic int b = m_busy;
         automatic bit rx_fin = (b != 0) && (b == 3 * m_per - m_per / 2);
         automatic bit go = (b == 0) && m_thr_full && m_en && (!rx_gate || !m_rxr);
         automatic bit take = wr_thr && m_en && !m_thr_full;
         automatic bit ovr_set = rx_fin && m_rxr && !rd_rhr;
         if (rx_fin) begin
            m_rhr = m_cur_slave;
            m_rxr = 1;
         end else if (rd_rhr) begin
            m_rxr = 0;
         end
         if (ovr_set) m_ovr = 1;
         else if (c_clr) m_ovr = 0;
         if (go) begin
            m_per = (bit_div < 2) ? 2 : int'(bit_div);
            m_busy = 11 * m_per;
            m_cur_tx = m_thr;
            m_cur_slave = slave_pat(m_frames);
            m_frames++;
            sent_q.push_back(m_thr);
            m_thr_full = 0;
         end else if (b > 0) begin
            m_busy = b - 1;
         end
         if (take) begin m_thr_full = 1; m_thr = wr_data; end
         if (c_off) m_en = 0; else if (c_on) m_en = 1;
         if (c_free) m_hold = 0; else if (c_hold) m_hold = 1;
      end
   end

   // ---------------- bench slave on the serial lines ----------------
   int         sl_cnt = 0;
   int         mo_cnt = 0;
   int         mo_frames = 0;
   logic [7:0] mo_byte = 0;
   logic       prev_sck = 0;
   assign spi_miso = m_cur_slave[3'(7 - sl_cnt)];

   // ---------------- compare on every clock ----------------
   always @(negedge clk) begin
      if (rst_n && !done_run) begin
         automatic int k = 11 * m_per - m_busy;
         automatic bit in_data = (m_busy > 0) && (k >= m_per) && (k < 9 * m_per);
         automatic int e_sck = (in_data && ((k % m_per) >= m_per / 2)) ? 1 : 0;
         automatic int e_mosi = in_data ? int'(m_cur_tx[3'(7 - (k - m_per) / m_per)]) : 0;
         automatic int e_txr = (m_en && !m_thr_full) ? 1 : 0;
         chk("R2", "tx_ready", int'(tx_ready), e_txr);
         chk("R2", "tx_empty", int'(tx_empty), (e_txr == 1 && m_busy == 0) ? 1 : 0);
         chk("R6", "rx_ready", int'(rx_ready), int'(m_rxr));
         chk("R6", "rd_data", int'(rd_data), int'(m_rhr));
         chk("R8", "overrun", int'(overrun), int'(m_ovr));
         chk("R5", "spi_sck", int'(spi_sck), e_sck);
         chk("R5", "spi_mosi", int'(spi_mosi), e_mosi);
         chk("R10", "spi_cs_n", int'(spi_cs_n), (m_hold || m_busy > m_per) ? 0 : 1);
         if (spi_sck && !prev_sck) begin
            mo_byte = {mo_byte[6:0], spi_mosi};
            mo_cnt++;
            if (mo_cnt == 8) begin
               mo_cnt = 0;
               mo_frames++;
               if (sent_q.size() > 0) chk("R5", "serial byte", int'(mo_byte), int'(sent_q.pop_front()));
               else chk("R1", "unexpected frame", 1, 0);
            end
         end
         if (!spi_sck && prev_sck) sl_cnt = (sl_cnt == 7) ? 0 : sl_cnt + 1;
         prev_sck = spi_sck;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(logic [7:0] v);
      wr_thr = 1; wr_data = v; @(negedge clk); wr_thr = 0;
   endtask

   task automatic rd_pulse();
      rd_rhr = 1; @(negedge clk); rd_rhr = 0;
   endtask

   task automatic cmd_pulse(int which);
      case (which)
         0: c_on = 1;
         1: c_off = 1;
         2: c_hold = 1;
         3: c_free = 1;
         default: c_clr = 1;
      endcase
      @(negedge clk);
      c_on = 0; c_off = 0; c_hold = 0; c_free = 0; c_clr = 0;
   endtask

   task automatic wait_idle();
      while (!(m_busy == 0 && !m_thr_full)) @(negedge clk);
      cyc(2);
   endtask

   int base;
   int nlow;

   initial begin
      cyc(3);
      rst_n = 1;
      @(negedge clk);
      // R2 reset state
      chk("R2", "reset tx_ready", int'(tx_ready), 0);
      chk("R2", "reset cs_n", int'(spi_cs_n), 1);
      chk("R2", "reset rd_data", int'(rd_data), 0);

      // R3 / R1: start timing, queued write, discarded write
      bit_div = 8'd4;
      cmd_pulse(0);
      chk("R2", "enabled tx_empty", int'(tx_empty), 1);
      base = mo_frames;
      put(8'hA5);
      chk("R1", "holding full", int'(tx_ready), 0);
      @(negedge clk);
      chk("R3", "holding emptied at start", int'(tx_ready), 1);
      chk("R3", "cs falls at start", int'(spi_cs_n), 0);
      put(8'h3C);
      put(8'h77);            // tx_ready low here: discarded
      chk("R1", "still full", int'(tx_ready), 0);
      wait_idle();
      chk("R1", "frames sent", mo_frames - base, 2);
      chk("R8", "overrun after second char", int'(overrun), 1);
      chk("R6", "last received", int'(rd_data), int'(slave_pat(1)));

      // R7 / R9
      rd_pulse();
      chk("R7", "read clears ready", int'(rx_ready), 0);
      chk("R9", "overrun kept after read", int'(overrun), 1);
      cmd_pulse(4);
      chk("R9", "clear status", int'(overrun), 0);

      // R4 receive handshake
      rx_gate = 1;
      put(8'h11);
      wait_idle();
      chk("R4", "ready before gate", int'(rx_ready), 1);
      put(8'h22);
      cyc(60);
      chk("R4", "gated cs idle", int'(spi_cs_n), 1);
      chk("R4", "gated char pending", int'(tx_ready), 0);
      rd_pulse();
      chk("R4", "no start at read edge", int'(spi_cs_n), 1);
      @(negedge clk);
      chk("R4", "start after read", int'(spi_cs_n), 0);
      wait_idle();
      rx_gate = 0;
      rd_pulse();

      // R10 forced chip-select
      cmd_pulse(2);
      chk("R10", "forced low idle", int'(spi_cs_n), 0);
      put(8'hC3);
      @(negedge clk);
      put(8'h5A);
      wait_idle();
      chk("R10", "still forced", int'(spi_cs_n), 0);
      cmd_pulse(3);
      chk("R10", "released", int'(spi_cs_n), 1);
      rd_pulse();
      cmd_pulse(4);

      // R11 period floor and odd period
      bit_div = 8'd0;
      put(8'h96);
      @(negedge clk);
      nlow = 0;
      while (!spi_cs_n && nlow < 100) begin nlow++; @(negedge clk); end
      chk("R11", "cs low width with div 0", nlow, 20);
      wait_idle();
      bit_div = 8'd3;
      put(8'hE1);
      wait_idle();
      chk("R11", "odd period data", int'(rd_data), int'(slave_pat(m_frames - 1)));
      rd_pulse();
      cmd_pulse(4);

      // R12 disable mid-frame
      bit_div = 8'd4;
      base = mo_frames;
      put(8'h0F);
      cyc(10);
      cmd_pulse(1);
      chk("R12", "disabled tx_ready", int'(tx_ready), 0);
      chk("R12", "disabled tx_empty", int'(tx_empty), 0);
      put(8'hF0);
      while (m_busy != 0) @(negedge clk);
      cyc(30);
      chk("R12", "frame finished, write dropped", mo_frames - base, 1);
      chk("R12", "idle cs", int'(spi_cs_n), 1);
      cmd_pulse(0);
      chk("R12", "re-enabled empty", int'(tx_empty), 1);
      cyc(5);

      done_run = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         done_run = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule